// File: doc/BRIEF.md
# Adaptive Hysteresis Threshold Calculator

This block maintains the two hysteresis bands of a digital current-error controller: a positive band above zero and a negative band below it. Each time the zero-crossing unit reports a crossing, it pulses a strobe and says which band the current error is now heading towards. The block then recomputes that band from time measurements alone. The inputs to that computation are the synchronization error of the half-period just completed, the length of the opposite half-period, the opposite band's present value, and the overshoot errors the crossing detector measured after each band was crossed. No supply voltage or inductance enters the computation.

The ratio of the remaining half-period to the measured half-period is formed by a restoring divider that produces one quotient bit per clock. The ratio scales the opposite band, and the stored overshoot terms are added. Because of these terms the two bands drift apart on purpose, so that the average current error stays at zero when dead time is present. A result that is too small, has the wrong sign or comes from a zero-length half-period is not applied: the band keeps its last good value and a saturation flag is raised. Both bands are presented continuously to the crossing detector.

Top module: `hyst_thr_calc`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `thrPos` = +`initMag` and `thrNeg` = −`initMag`. At the same time `satPos`, `satNeg` and `busy` are 0, and both stored overshoot terms are zero.
- R2: With `updPol` = 0 the negative band gets the value −floor(q·(thrPos + dPos) / 2^FRAC) − dNeg. Here q = floor(num·2^FRAC / `halfPer`), num = `halfCnt` − `syncErr`, and dPos and dNeg are the stored overshoot terms.
- R3: With `updPol` = 1 the positive band gets the mirrored value −floor(q·(thrNeg + dNeg) / 2^FRAC) − dPos, with q formed in the same way.
- R4: When `syncErr` ≥ `halfCnt`, num is taken as zero, so the scaled part of the result is zero.
- R5: A strobe accepted at rising edge E raises `busy` after E. Both bands stay unchanged through edge E+QW, where QW = CW+1+FRAC. The new value and `busy` = 0 appear after edge E+QW+1.
- R6: A strobe is accepted only while `busy` is 0. A strobe arriving while `busy` is 1 is dropped and causes no later update.
- R7: A positive result below `minMag`, or a negative result above −`minMag`, leaves that band at its previous value and sets its saturation flag. The next update of that band that is not saturated writes the band and clears the flag.
- R8: When `halfPer` is 0 the update is treated as saturated (R7), whatever the other inputs are.
- R9: A pulse on `errStb` stores `errVal` as the overshoot of the positive band (`errPol` = 1) or of the negative band (`errPol` = 0). The stored terms are read at the edge that accepts an update strobe.
- R10: An update writes only the band it targets. The other band is never adjusted to mirror it.
- R11: A result outside ±(2^(DW−1)−1) is clamped to that limit before the saturation test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| initMag | input | DW | Band magnitude loaded at reset |
| minMag | input | DW | Smallest band magnitude that is accepted |
| halfCnt | input | CW | Target half-period in clock counts |
| updStb | input | 1 | Update request from the zero-crossing unit |
| updPol | input | 1 | 1: update positive band, 0: update negative band |
| syncErr | input | CW+1 | Signed synchronization error in counts |
| halfPer | input | CW | Measured opposite half-period in counts |
| errStb | input | 1 | Overshoot measurement valid |
| errPol | input | 1 | 1: overshoot of positive band, 0: of negative band |
| errVal | input | DW | Signed overshoot value |
| thrPos | output | DW | Positive band, signed |
| thrNeg | output | DW | Negative band, signed |
| satPos | output | 1 | Positive band held by saturation |
| satNeg | output | 1 | Negative band held by saturation |
| busy | output | 1 | Computation in progress |

## Verification
The update is first driven with a small positive synchronization error and zero overshoot terms, which isolates the divide and scale path. Next comes a negative error with non-zero overshoot terms on both bands, so a swapped or misplaced overshoot term shows up in the result. Patterns with a late crossing (numerator below zero), a zero half-period, a one-count half-period that overflows the band range, and a second strobe arriving mid-computation each drive one of the special cases: clamping, saturation hold and its release, the range limit, and dropping a request. The non-target band is compared after every update, which catches any mirroring.

// File: rtl/hyst_thr_pkg.sv
package hyst_thr_pkg;
  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;    // capture operands, seed divider
    logic step;    // one restoring-divide iteration
    logic commit;  // scale, clamp, saturate, write band
  } thrCtl_t;
endpackage

// File: rtl/hyst_thr_ctrl.sv
module hyst_thr_ctrl
  import hyst_thr_pkg::*;
#(
  parameter int QW = 21
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    updStb,
  output thrCtl_t ctl,
  output logic    busy
);
  localparam int CNTW = $clog2(QW + 1);

  typedef enum logic [1:0] {IDLE, RUN, DONE} seqSt_t;

  seqSt_t          st;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE: if (updStb) begin
          st  <= RUN;
          cnt <= CNTW'(QW);
        end
        RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNTW'(1)) st <= DONE;
        end
        DONE: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load   = (st == IDLE) && updStb;
    ctl.step   = (st == RUN);
    ctl.commit = (st == DONE);
    busy       = (st != IDLE);
  end

  // R5: busy persists until the commit cycle
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.commit) |=> busy);
  // R5: a fresh computation starts with the full iteration count
  p_start_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (cnt == CNTW'(QW)));
  // R6: a strobe on the commit cycle is not accepted
  p_no_chain_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> !busy);
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNTW'(QW));
endmodule

// File: rtl/hyst_thr_dp.sv
module hyst_thr_dp
  import hyst_thr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 12,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  thrCtl_t              ctl,
  input  logic [DW-1:0]        initMag,
  input  logic [DW-1:0]        minMag,
  input  logic [CW-1:0]        halfCnt,
  input  logic                 updPol,
  input  logic signed [CW:0]   syncErr,
  input  logic [CW-1:0]        halfPer,
  input  logic                 errStb,
  input  logic                 errPol,
  input  logic signed [DW-1:0] errVal,
  output logic signed [DW-1:0] thrPos,
  output logic signed [DW-1:0] thrNeg,
  output logic                 satPos,
  output logic                 satNeg
);
  localparam int QW = CW + 1 + FRAC;   // quotient width
  localparam int PW = QW + DW + 2;     // product width
  localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV;

  // band and overshoot state
  logic signed [DW-1:0] thrPosQ, thrNegQ, dPosQ, dNegQ;
  logic                 satPosQ, satNegQ;

  // captured operands and divider state
  logic [QW-1:0]        opQuo;
  logic [CW:0]          opRem;
  logic [CW-1:0]        opDiv;
  logic                 opDivZero;
  logic signed [DW:0]   opBase;
  logic signed [DW-1:0] opOwn;
  logic                 opPol;

  // operand preparation
  logic signed [CW+1:0] diff;
  logic [CW:0]          num;
  logic signed [DW-1:0] oppThr, oppD, ownD;
  logic signed [DW:0]   base;

  always_comb begin
    diff   = $signed({2'b00, halfCnt}) - $signed({syncErr[CW], syncErr});
    num    = diff[CW+1] ? '0 : diff[CW:0];
    oppThr = updPol ? thrNegQ : thrPosQ;
    oppD   = updPol ? dNegQ   : dPosQ;
    ownD   = updPol ? dPosQ   : dNegQ;
    base   = $signed({oppThr[DW-1], oppThr}) + $signed({oppD[DW-1], oppD});
  end

  // restoring divide iteration
  logic [CW+1:0] remSh, remSub;
  logic          fits;

  always_comb begin
    remSh  = {opRem, opQuo[QW-1]};
    remSub = remSh - {2'b00, opDiv};
    fits   = (remSh >= {2'b00, opDiv});
  end

  // scale, offset, clamp and saturation test
  logic signed [PW-1:0] prod, val;
  logic signed [DW-1:0] clampV;
  logic signed [DW:0]   clampExt, minS;
  logic                 satHit;

  always_comb begin
    prod = $signed({{(DW + 2){1'b0}}, opQuo}) * $signed({{(QW + 1){opBase[DW]}}, opBase});
    val  = -(prod >>> FRAC) - $signed({{(PW - DW){opOwn[DW-1]}}, opOwn});
    if (val > MAXV)      clampV = MAXV[DW-1:0];
    else if (val < MINV) clampV = MINV[DW-1:0];
    else                 clampV = val[DW-1:0];
    clampExt = $signed({clampV[DW-1], clampV});
    minS     = $signed({1'b0, minMag});
    satHit   = opDivZero || (opPol ? (clampExt < minS) : (clampExt > -minS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrPosQ   <= $signed(initMag);
      thrNegQ   <= -$signed(initMag);
      dPosQ     <= '0;
      dNegQ     <= '0;
      satPosQ   <= 1'b0;
      satNegQ   <= 1'b0;
      opQuo     <= '0;
      opRem     <= '0;
      opDiv     <= '0;
      opDivZero <= 1'b0;
      opBase    <= '0;
      opOwn     <= '0;
      opPol     <= 1'b0;
    end else begin
      if (errStb) begin
        if (errPol) dPosQ <= errVal;
        else        dNegQ <= errVal;
      end
      if (ctl.load) begin
        opQuo     <= {num, {FRAC{1'b0}}};
        opRem     <= '0;
        opDiv     <= halfPer;
        opDivZero <= (halfPer == '0);
        opBase    <= base;
        opOwn     <= ownD;
        opPol     <= updPol;
      end else if (ctl.step) begin
        opRem <= fits ? remSub[CW:0] : remSh[CW:0];
        opQuo <= {opQuo[QW-2:0], fits};
      end
      if (ctl.commit) begin
        if (opPol) begin
          satPosQ <= satHit;
          if (!satHit) thrPosQ <= clampV;
        end else begin
          satNegQ <= satHit;
          if (!satHit) thrNegQ <= clampV;
        end
      end
    end
  end

  assign thrPos = thrPosQ;
  assign thrNeg = thrNegQ;
  assign satPos = satPosQ;
  assign satNeg = satNegQ;

  // R5: bands move only on a commit cycle
  p_band_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> ($stable(thrPosQ) && $stable(thrNegQ)));
  // R10: updating one band leaves the other alone
  p_pos_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && opPol) |=> $stable(thrNegQ));
  p_neg_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && !opPol) |=> $stable(thrPosQ));
  // R7: a saturated result holds the band and raises its flag
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && satHit && opPol) |=> ($stable(thrPosQ) && satPosQ));
  // R11: the most negative code never appears after a commit
  p_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (thrNegQ != {1'b1, {(DW - 1){1'b0}}}));
  // R2: restoring remainder stays below the divisor
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> (opDivZero || (opRem < {1'b0, opDiv})));
endmodule

// File: rtl/hyst_thr_calc.sv
module hyst_thr_calc
  import hyst_thr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 12,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DW-1:0]        initMag,
  input  logic [DW-1:0]        minMag,
  input  logic [CW-1:0]        halfCnt,
  input  logic                 updStb,
  input  logic                 updPol,
  input  logic signed [CW:0]   syncErr,
  input  logic [CW-1:0]        halfPer,
  input  logic                 errStb,
  input  logic                 errPol,
  input  logic signed [DW-1:0] errVal,
  output logic signed [DW-1:0] thrPos,
  output logic signed [DW-1:0] thrNeg,
  output logic                 satPos,
  output logic                 satNeg,
  output logic                 busy
);
  localparam int QW = CW + 1 + FRAC;

  thrCtl_t ctl;

  hyst_thr_ctrl #(.QW(QW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .updStb (updStb),
    .ctl    (ctl),
    .busy   (busy)
  );

  hyst_thr_dp #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .initMag (initMag),
    .minMag  (minMag),
    .halfCnt (halfCnt),
    .updPol  (updPol),
    .syncErr (syncErr),
    .halfPer (halfPer),
    .errStb  (errStb),
    .errPol  (errPol),
    .errVal  (errVal),
    .thrPos  (thrPos),
    .thrNeg  (thrNeg),
    .satPos  (satPos),
    .satNeg  (satNeg)
  );
endmodule

// File: tb/sim_hyst_thr_calc.sv
`timescale 1ns/1ps
module sim_hyst_thr_calc;
  localparam int DW = 16, CW = 12, FRAC = 8;
  localparam int QW = CW + 1 + FRAC;
  localparam longint INITM = 1000, MINM = 100, HALF = 250, LIM = 32767;

  logic clk = 1'b0, rstN = 1'b0;
  logic [DW-1:0] initMag = DW'(INITM), minMag = DW'(MINM);
  logic [CW-1:0] halfCnt = CW'(HALF), halfPer = '0;
  logic updStb = 1'b0, updPol = 1'b0, errStb = 1'b0, errPol = 1'b0;
  logic signed [CW:0] syncErr = '0;
  logic signed [DW-1:0] errVal = '0;
  logic signed [DW-1:0] thrPos, thrNeg;
  logic satPos, satNeg, busy;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  longint mPos, mNeg, mDPos, mDNeg;
  bit mSatP, mSatN;

  always #5 clk = ~clk;

  hyst_thr_calc #(.DW(DW), .CW(CW), .FRAC(FRAC)) u0 (
    .clk(clk), .rstN(rstN), .initMag(initMag), .minMag(minMag), .halfCnt(halfCnt),
    .updStb(updStb), .updPol(updPol), .syncErr(syncErr), .halfPer(halfPer),
    .errStb(errStb), .errPol(errPol), .errVal(errVal),
    .thrPos(thrPos), .thrNeg(thrNeg), .satPos(satPos), .satNeg(satNeg), .busy(busy));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint calcVal(longint terr, longint thp, longint opp,
                                     longint dOpp, longint dOwn);
    longint num, q, t, v;
    num = HALF - terr;
    if (num < 0) num = 0;
    q = (num <<< FRAC) / thp;
    t = (q * (opp + dOpp)) >>> FRAC;
    v = -t - dOwn;
    if (v > LIM) v = LIM;
    if (v < -LIM) v = -LIM;
    return v;
  endfunction

  task automatic checkAll(input string req);
    chk(thrPos == mPos, {req, " thrPos"}, thrPos, mPos);
    chk(thrNeg == mNeg, {req, " thrNeg"}, thrNeg, mNeg);
    chk(satPos == mSatP, {req, " satPos"}, satPos, mSatP);
    chk(satNeg == mSatN, {req, " satNeg"}, satNeg, mSatN);
  endtask

  task automatic setErr(input bit pol, input int v);
    @(negedge clk);
    errStb = 1'b1; errPol = pol; errVal = DW'(v);
    @(negedge clk);
    errStb = 1'b0;
    if (pol) mDPos = v; else mDNeg = v;
  endtask

  // one update; optional intruding strobe mid-computation (R6)
  task automatic doUpdate(input bit pol, input int terr, input int thp,
                          input string req, input bit intrude);
    longint v;
    bit sat;
    if (pol) begin
      v = (thp == 0) ? 0 : calcVal(terr, thp, mNeg, mDNeg, mDPos);
      sat = (thp == 0) || (v < MINM);
    end else begin
      v = (thp == 0) ? 0 : calcVal(terr, thp, mPos, mDPos, mDNeg);
      sat = (thp == 0) || (v > -MINM);
    end
    @(negedge clk);
    updStb = 1'b1; updPol = pol; syncErr = (CW+1)'(terr); halfPer = CW'(thp);
    @(negedge clk);
    updStb = 1'b0;
    chk(busy == 1'b1, {req, " R5 busy after accept"}, busy, 1);
    for (int i = 0; i < QW; i++) begin
      if (intrude && i == 2) begin
        updStb = 1'b1; updPol = ~pol; syncErr = '0; halfPer = CW'(1);
      end else if (intrude && i == 3) begin
        updStb = 1'b0;
      end
      @(negedge clk);
    end
    chk(thrPos == mPos && thrNeg == mNeg, {req, " R5 no early change"}, thrPos, mPos);
    @(negedge clk);
    if (pol) begin
      mSatP = sat;
      if (!sat) mPos = v;
    end else begin
      mSatN = sat;
      if (!sat) mNeg = v;
    end
    chk(busy == 1'b0, {req, " R5 busy cleared"}, busy, 0);
    checkAll({req, " R10"});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    checkAll("R1 during reset");
    chk(busy == 1'b0, "R1 busy", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");
  endtask

  task automatic t_neg_basic();
    doUpdate(1'b0, 10, 260, "R2", 1'b0);
  endtask

  task automatic t_pos_with_err();
    setErr(1'b1, 30);
    setErr(1'b0, -20);
    doUpdate(1'b1, -5, 240, "R3 R9", 1'b0);
    doUpdate(1'b0, 3, 245, "R2 R9", 1'b0);
  endtask

  task automatic t_late_cross();
    doUpdate(1'b0, 300, 250, "R4 R7", 1'b0);
    chk(satNeg == 1'b1, "R7 flag set", satNeg, 1);
    doUpdate(1'b0, 0, 250, "R7 release", 1'b0);
    chk(satNeg == 1'b0, "R7 flag cleared", satNeg, 0);
  endtask

  task automatic t_zero_div();
    doUpdate(1'b1, 0, 0, "R8", 1'b0);
    chk(satPos == 1'b1, "R8 flag", satPos, 1);
    doUpdate(1'b1, 0, 250, "R8 release", 1'b0);
  endtask

  task automatic t_drop();
    doUpdate(1'b1, 7, 255, "R6", 1'b1);
    repeat (QW + 5) @(negedge clk);
    checkAll("R6 no late update");
    chk(busy == 1'b0, "R6 idle", busy, 0);
  endtask

  task automatic t_clamp();
    doUpdate(1'b0, -250, 1, "R11", 1'b0);
    chk(thrNeg == -LIM, "R11 limit", thrNeg, -LIM);
  endtask

  task automatic t_asym();
    chk(thrPos != -thrNeg, "R10 bands not mirrored", thrPos, -thrNeg);
  endtask

  initial begin
    mPos = INITM; mNeg = -INITM; mDPos = 0; mDNeg = 0; mSatP = 0; mSatN = 0;
    t_reset();
    t_neg_basic();
    t_pos_with_err();
    t_late_cross();
    t_zero_div();
    t_drop();
    t_clamp();
    t_asym();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule